// File: doc/BRIEF.md
# SRAM Access Strobe Sequencer

This block sits between a clocked system and an asynchronous static RAM array. The system raises a read request or a write request. The block turns that request into a timed sequence of four array strobes:

- an active-low precharge strobe that charges the bitlines;
- an active-low sense strobe that fires the sense amplifiers;
- an active-high write strobe that drives write data onto the bitlines;
- an active-high address strobe that opens the row decoder.

A read always charges the bitlines first and senses them afterwards. The two phases never overlap. A write opens the address path and the write drivers together. The array, its decoder and the data path are outside this block.

Requests are decoded only while the sequencer is idle. A request that asks for both a read and a write at once counts as no operation. An operation in progress runs its full length whatever the request lines do. A busy flag covers every non-idle cycle. A one-cycle done pulse marks the final cycle of each operation. Parameters set the length of each phase; each defaults to one clock.

Top module: `sram_acc_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs are pre_n_o=1, rd_n_o=1, wr_en_o=0, addr_en_o=0, busy_o=0 and done_o=0.
- R2: In idle, a request pair {rd_req_i, wr_req_i} of 00 or 11 at a clock edge leaves the block idle, with all strobes at their deasserted values as in R1.
- R3: When {rd_req_i, wr_req_i}=10 at an edge in idle, the next PRE_LEN cycles show pre_n_o=0, rd_n_o=1, addr_en_o=0 and wr_en_o=0.
- R4: SENSE_LEN cycles of rd_n_o=0 and addr_en_o=1 follow the precharge phase directly. During them pre_n_o=1 and wr_en_o=0.
- R5: pre_n_o and rd_n_o are never low in the same cycle, and wr_en_o is never high while rd_n_o is low.
- R6: When {rd_req_i, wr_req_i}=01 at an edge in idle, the next WR_LEN cycles show wr_en_o=1 and addr_en_o=1, with pre_n_o=1 and rd_n_o=1.
- R7: Request inputs have no effect while busy. A cycle in progress is neither shortened nor redirected.
- R8: busy_o is 1 in every precharge, sense and write cycle, and 0 in idle.
- R9: done_o is 1 only in the last cycle of a sense phase or of a write phase, and never for two cycles in a row.
- R10: After each operation the block spends at least one cycle idle with all strobes deasserted. The request present at the end of that cycle is then decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request |
| wr_req_i | input | 1 | Write request |
| pre_n_o | output | 1 | Bitline precharge strobe, active low |
| rd_n_o | output | 1 | Sense strobe, active low |
| wr_en_o | output | 1 | Write driver strobe, active high |
| addr_en_o | output | 1 | Address decoder strobe, active high |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of an operation |

## Verification
All outputs are decoded from registered state, so a request at edge k first shows on the strobes in the cycle after edge k. The precharge phase then lasts PRE_LEN cycles. The sense phase follows directly for SENSE_LEN cycles, or a write lasts WR_LEN cycles, and one idle cycle comes after either. The bench drives inputs at the falling edge and checks every output vector at the next falling edge, once for each cycle of these expected windows. It sweeps all four request codes, each with all four codes held on the request lines during the busy cycles. It runs a non-default phase length so that the hold counter is exercised.

// File: rtl/sram_acc_pkg.sv
package sram_acc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_SENSE = 2'd2,
    ST_WRITE = 2'd3
  } acc_state_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } acc_op_e;

  typedef struct packed {
    logic pre_n;
    logic rd_n;
    logic wr_en;
    logic addr_en;
  } strobe_t;
endpackage

// File: rtl/sram_acc_req_decode.sv
module sram_acc_req_decode
  import sram_acc_pkg::*;
(
  input  logic    rd_req_i,
  input  logic    wr_req_i,
  output acc_op_e op_o
);
  // both requests at once is treated as no operation
  always_comb begin
    unique case ({rd_req_i, wr_req_i})
      2'b10:   op_o = OP_READ;
      2'b01:   op_o = OP_WRITE;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/sram_acc_seq.sv
module sram_acc_seq
  import sram_acc_pkg::*;
#(
  parameter int unsigned PRE_LEN   = 1,
  parameter int unsigned SENSE_LEN = 1,
  parameter int unsigned WR_LEN    = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  acc_op_e    op_i,
  output acc_state_e state_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned LEN_A   = (PRE_LEN > SENSE_LEN) ? PRE_LEN : SENSE_LEN;
  localparam int unsigned LEN_MAX = (LEN_A > WR_LEN) ? LEN_A : WR_LEN;
  localparam int unsigned CW      = $clog2(LEN_MAX + 1);

  acc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, len_m1;
  logic          last;

  always_comb begin
    unique case (state_q)
      ST_PRE:   len_m1 = CW'(PRE_LEN - 1);
      ST_SENSE: len_m1 = CW'(SENSE_LEN - 1);
      ST_WRITE: len_m1 = CW'(WR_LEN - 1);
      default:  len_m1 = '0;
    endcase
  end

  assign last = (cnt_q == len_m1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (op_i == OP_READ)       state_d = ST_PRE;
        else if (op_i == OP_WRITE) state_d = ST_WRITE;
      end
      ST_PRE:   if (last) state_d = ST_SENSE;
      ST_SENSE: if (last) state_d = ST_IDLE;
      ST_WRITE: if (last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q || state_q == ST_IDLE) cnt_d = '0;
    else                                          cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = last && (state_q == ST_SENSE || state_q == ST_WRITE);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && op_i == OP_NONE) |=> (state_q == ST_IDLE)); // R2
  AST_SENSE_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SENSE && $past(state_q) != ST_SENSE) |-> ($past(state_q) == ST_PRE)); // R4
  AST_NO_SHORTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !last) |=> $stable(state_q)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RETURN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/sram_acc_strobe_gen.sv
module sram_acc_strobe_gen
  import sram_acc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  acc_state_e state_i,
  output strobe_t    strobe_o
);
  always_comb begin
    strobe_o = '{pre_n: 1'b1, rd_n: 1'b1, wr_en: 1'b0, addr_en: 1'b0};
    unique case (state_i)
      ST_PRE:   strobe_o.pre_n = 1'b0;
      ST_SENSE: begin
        strobe_o.rd_n    = 1'b0;
        strobe_o.addr_en = 1'b1;
      end
      ST_WRITE: begin
        strobe_o.wr_en   = 1'b1;
        strobe_o.addr_en = 1'b1;
      end
      default: ;
    endcase
  end

  AST_PRE_SENSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!strobe_o.pre_n && !strobe_o.rd_n)); // R5
  AST_NO_WRITE_IN_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_o.wr_en && !strobe_o.rd_n)); // R5
  AST_WRITE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o.wr_en |-> (strobe_o.addr_en && strobe_o.pre_n)); // R6
endmodule

// File: rtl/sram_acc_ctrl.sv
module sram_acc_ctrl
  import sram_acc_pkg::*;
#(
  parameter int unsigned PRE_LEN   = 1,
  parameter int unsigned SENSE_LEN = 1,
  parameter int unsigned WR_LEN    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic pre_n_o,
  output logic rd_n_o,
  output logic wr_en_o,
  output logic addr_en_o,
  output logic busy_o,
  output logic done_o
);
  acc_op_e    op;
  acc_state_e state;
  strobe_t    strobe;

  sram_acc_req_decode u_dec (
    .rd_req_i (rd_req_i),
    .wr_req_i (wr_req_i),
    .op_o     (op)
  );

  sram_acc_seq #(
    .PRE_LEN   (PRE_LEN),
    .SENSE_LEN (SENSE_LEN),
    .WR_LEN    (WR_LEN)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .state_o (state),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sram_acc_strobe_gen u_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .strobe_o (strobe)
  );

  assign pre_n_o   = strobe.pre_n;
  assign rd_n_o    = strobe.rd_n;
  assign wr_en_o   = strobe.wr_en;
  assign addr_en_o = strobe.addr_en;

  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (!pre_n_o || !rd_n_o || wr_en_o)); // R8
endmodule

// File: tb/tb_sram_acc_ctrl.sv
module tb_sram_acc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_LEN    = 2;
  localparam int SENSE_LEN  = 1;
  localparam int WR_LEN     = 3;
  localparam int WD_LIMIT   = 5000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic pre_n, rd_n, wr_en, addr_en, busy, done;
  int   checks = 0, failures = 0;
  int   cycles = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_acc_ctrl #(.PRE_LEN(PRE_LEN), .SENSE_LEN(SENSE_LEN), .WR_LEN(WR_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .pre_n_o(pre_n), .rd_n_o(rd_n), .wr_en_o(wr_en), .addr_en_o(addr_en),
    .busy_o(busy), .done_o(done));

  // vector order: {pre_n, rd_n, wr_en, addr_en, busy, done}
  localparam logic [5:0] V_IDLE  = 6'b110000;
  localparam logic [5:0] V_PRE   = 6'b010010;
  localparam logic [5:0] V_SENSE = 6'b100110;
  localparam logic [5:0] V_WRITE = 6'b111110;

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {pre_n, rd_n, wr_en, addr_en, busy, done};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
    end
    checks++;
    if (!pre_n && !rd_n) begin
      failures++;
      $display("FAIL R5: got pre_n=%b rd_n=%b expected not both low", pre_n, rd_n);
    end
  endtask

  // issue code {rd,wr}; hold noise on the request lines while busy
  task automatic run_op(input logic [1:0] code, input logic [1:0] noise);
    @(negedge clk);
    {rd_req, wr_req} = code;
    @(negedge clk);
    if (code == 2'b10) begin
      for (int i = 0; i < PRE_LEN; i++) begin
        {rd_req, wr_req} = noise;
        chk("R3 precharge (R7 noise, R8 busy)", V_PRE);
        @(negedge clk);
      end
      for (int i = 0; i < SENSE_LEN; i++) begin
        {rd_req, wr_req} = (i == SENSE_LEN-1) ? 2'b00 : noise;
        chk("R4 sense (R9 done, R7 noise)", V_SENSE | {5'b0, i == SENSE_LEN-1});
        @(negedge clk);
      end
      chk("R10 idle after read", V_IDLE);
    end else if (code == 2'b01) begin
      for (int i = 0; i < WR_LEN; i++) begin
        {rd_req, wr_req} = (i == WR_LEN-1) ? 2'b00 : noise;
        chk("R6 write (R9 done, R7 noise)", V_WRITE | {5'b0, i == WR_LEN-1});
        @(negedge clk);
      end
      chk("R10 idle after write", V_IDLE);
    end else begin
      {rd_req, wr_req} = 2'b00;
      chk("R2 idle code", V_IDLE);
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !finished) begin
        failures++;
        $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", V_IDLE);
    rd_req = 1'b1;  // request while in reset must have no effect
    @(negedge clk);
    chk("R1 in reset with request", V_IDLE);
    rd_req = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", V_IDLE);

    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++)
        run_op(2'(c), 2'(n));

    // back-to-back: request held high across a write, then a read
    @(negedge clk);
    {rd_req, wr_req} = 2'b01;
    @(negedge clk);
    for (int i = 0; i < WR_LEN; i++) begin
      chk("R7 held write request", V_WRITE | {5'b0, i == WR_LEN-1});
      if (i == WR_LEN-1) {rd_req, wr_req} = 2'b10;
      @(negedge clk);
    end
    chk("R10 one idle cycle between ops", V_IDLE);
    @(negedge clk);
    {rd_req, wr_req} = 2'b00;
    chk("R10 next request decoded", V_PRE);

    // reset mid-operation returns to idle
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-read", V_IDLE);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after mid-read reset", V_IDLE);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule